// File: doc/BRIEF.md
# Dual-Side Mailbox Interrupt Controller

This block gathers interrupt events for a device that sits between a host bus and a local processor. It keeps two register views of the same set of event sources, one for each side. Each view has its own status, mask and control registers, and each view drives its own interrupt output. The event sources are DMA completion, a mailbox write, message-queue not-empty, message-queue overflow, master abort, target abort and an external interrupt pin. The DMA engine, the queues and the bus logic deliver these events as single-cycle pulses or as levels.

Each side has a mailbox register. A write to it passes a data word across to the other side and sets that side's mailbox status bit. In this way the local processor can interrupt the host, and the host can interrupt the local processor. The host output is active high. The polarity of the local output is set by a control bit and is active low after reset. The block only raises these two request lines. It does no system-wide prioritisation or arbitration.

Top module: `xirq_hub`

## Requirements
- R1: After reset, both masks and both status registers are 0, all read data is 0, `host_irq` is 0 and `loc_irq_pin` is 1 (inactive, because the local output is active low after reset).
- R2: The status bit positions are as follows: 0 DMA done, 1 mailbox, 2 queue not empty, 3 queue overflow, 4 master abort, 5 target abort, 6 external pin. A pulse on `dma_done_p`, `q_ovf_p`, `mabort_p` or `tabort_p` sets the matching bit in both sides' status registers at the next clock edge, and the bit stays set.
- R3: A write to address 0 (status) clears every sticky bit (0, 1, 3, 4, 5) whose write-data bit is 1. Bits written as 0 keep their value. A clear on one side leaves the other side's status unchanged.
- R4: If a clear and a new event hit the same sticky bit in the same cycle, the bit stays set.
- R5: Status bits 2 and 6 follow `q_nempty` and `ext_irq` with a delay of one clock. Writes to the status register have no effect on them.
- R6: A write to address 2 (mailbox) on one side stores the data word where the other side reads it at its own address 2, and sets status bit 1 on the other side only.
- R7: Address 1 is the mask register of the side, bits [6:0]. It is written and read back on that side only.
- R8: `host_irq` is the OR over all sources of host status AND host mask, registered. It rises one clock after the status or mask makes the term true.
- R9: Local address 3, bit 0, selects the local output polarity: 0 is active low, 1 is active high. `loc_irq_pin` is the registered OR of local status AND local mask, driven in the selected polarity. On the host side, address 3 reads 0 and writes to it have no effect.
- R10: Read data is registered. `*_rdata` shows, one clock after an address is presented, the register contents from before that clock edge's updates.
- R11: The two sides are independent. A mask or control value on one side never changes the other side's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_done_p | input | 1 | DMA completion pulse |
| q_ovf_p | input | 1 | Message-queue overflow pulse |
| mabort_p | input | 1 | Master abort pulse |
| tabort_p | input | 1 | Target abort pulse |
| q_nempty | input | 1 | Message queue not empty (level) |
| ext_irq | input | 1 | External interrupt pin (level, active high) |
| h_wr_en | input | 1 | Host register write strobe |
| h_addr | input | 2 | Host register address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, registered |
| host_irq | output | 1 | Interrupt request to the host, active high |
| l_wr_en | input | 1 | Local register write strobe |
| l_addr | input | 2 | Local register address |
| l_wdata | input | DW | Local write data |
| l_rdata | output | DW | Local read data, registered |
| loc_irq_pin | output | 1 | Interrupt request to the local processor, programmable polarity |

## Verification
Status, mask, mailbox and polarity change at the clock edge that samples the stimulus. Read data and both interrupt outputs show those changes one edge later. An event therefore reaches an interrupt output two edges after it is sampled. The bench model steps at each rising edge. It computes the outputs from its pre-edge state and only then applies that edge's updates, which gives the same one-edge lag as the design. All outputs are compared at the falling edge, away from the edge that changes them.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NSRC = 7;

  localparam int SRC_DMA  = 0;
  localparam int SRC_MBOX = 1;
  localparam int SRC_QNE  = 2;
  localparam int SRC_OVF  = 3;
  localparam int SRC_MABT = 4;
  localparam int SRC_TABT = 5;
  localparam int SRC_EXT  = 6;

  // sources that follow a live level instead of latching
  localparam logic [NSRC-1:0] LEVEL_MAP = (NSRC'(1) << SRC_QNE) | (NSRC'(1) << SRC_EXT);

  typedef enum logic [1:0] {
    RA_STAT = 2'd0,
    RA_MASK = 2'd1,
    RA_MBOX = 2'd2,
    RA_CTRL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/xirq_status_bank.sv
module xirq_status_bank #(
  parameter int                 N       = 7,
  parameter logic [N-1:0]       LVL_MAP = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (LVL_MAP[i]) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else     stat[i] <= evt[i];
      end
    end else begin : g_sticky
      // a new event wins over a same-cycle clear
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else     stat[i] <= evt[i] | (stat[i] & ~clr[i]);
      end
    end
  end
endmodule

// File: rtl/xirq_side.sv
module xirq_side
  import xirq_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit HAS_POL = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NSRC-1:0] evt_in,
  input  logic [DW-1:0]   mb_rx_data,
  output logic            mb_tx_we,
  output logic [DW-1:0]   mb_tx_data,
  input  logic            mb_rx_we,
  output logic            irq_o,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] mask_o,
  output logic            pol_o
);
  localparam int PADW = DW - NSRC;

  reg_addr_e       ra;
  logic            we_stat, we_mask, we_mbox, we_ctrl;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] mask_q;
  logic [DW-1:0]   mbox_q;
  logic            pol_eff;
  logic            any_req;
  logic [DW-1:0]   rd_mux;

  assign ra      = reg_addr_e'(addr);
  assign we_stat = wr_en && (ra == RA_STAT);
  assign we_mask = wr_en && (ra == RA_MASK);
  assign we_mbox = wr_en && (ra == RA_MBOX);
  assign we_ctrl = wr_en && (ra == RA_CTRL);

  assign clr_vec = we_stat ? (wdata[NSRC-1:0] & ~LEVEL_MAP) : '0;

  xirq_status_bank #(.N(NSRC), .LVL_MAP(LEVEL_MAP)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .evt  (evt_in),
    .clr  (clr_vec),
    .stat (stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (we_mask) mask_q <= wdata[NSRC-1:0];
  end

  // word handed over by the opposite side
  always_ff @(posedge clk) begin
    if (rst)           mbox_q <= '0;
    else if (mb_rx_we) mbox_q <= mb_rx_data;
  end

  assign mb_tx_we   = we_mbox;
  assign mb_tx_data = wdata;

  if (HAS_POL) begin : g_pol
    logic pol_q;
    always_ff @(posedge clk) begin
      if (rst)          pol_q <= 1'b0;
      else if (we_ctrl) pol_q <= wdata[0];
    end
    assign pol_eff = pol_q;
  end else begin : g_fixed
    assign pol_eff = 1'b1;
  end

  assign any_req = |(stat_q & mask_q);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= HAS_POL ? 1'b1 : 1'b0;
    else     irq_o <= pol_eff ? any_req : ~any_req;
  end

  always_comb begin
    unique case (ra)
      RA_STAT: rd_mux = {{PADW{1'b0}}, stat_q};
      RA_MASK: rd_mux = {{PADW{1'b0}}, mask_q};
      RA_MBOX: rd_mux = mbox_q;
      default: rd_mux = {{(DW-1){1'b0}}, HAS_POL ? pol_eff : 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pol_o  = pol_eff;
endmodule

// File: rtl/xirq_hub.sv
module xirq_hub
  import xirq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_done_p,
  input  logic          q_ovf_p,
  input  logic          mabort_p,
  input  logic          tabort_p,
  input  logic          q_nempty,
  input  logic          ext_irq,
  input  logic          h_wr_en,
  input  logic [1:0]    h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          host_irq,
  input  logic          l_wr_en,
  input  logic [1:0]    l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          loc_irq_pin
);
  localparam int NSIDE = 2;  // 0 = host, 1 = local

  logic [NSIDE-1:0]           wr_a;
  logic [NSIDE-1:0][1:0]      addr_a;
  logic [NSIDE-1:0][DW-1:0]   wdata_a;
  logic [NSIDE-1:0][DW-1:0]   rdata_a;
  logic [NSIDE-1:0]           tx_we_a;
  logic [NSIDE-1:0][DW-1:0]   tx_data_a;
  logic [NSIDE-1:0]           irq_a;
  logic [NSIDE-1:0][NSRC-1:0] stat_a;
  logic [NSIDE-1:0][NSRC-1:0] mask_a;
  logic [NSIDE-1:0]           pol_a;
  logic [NSIDE-1:0][NSRC-1:0] evt_a;

  logic [NSRC-1:0] host_stat, loc_stat, host_mask, loc_mask;
  logic            loc_pol;

  assign wr_a    = {l_wr_en, h_wr_en};
  assign addr_a  = {l_addr, h_addr};
  assign wdata_a = {l_wdata, h_wdata};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int OTHER = NSIDE - 1 - s;

    always_comb begin
      evt_a[s]           = '0;
      evt_a[s][SRC_DMA]  = dma_done_p;
      evt_a[s][SRC_MBOX] = tx_we_a[OTHER];
      evt_a[s][SRC_QNE]  = q_nempty;
      evt_a[s][SRC_OVF]  = q_ovf_p;
      evt_a[s][SRC_MABT] = mabort_p;
      evt_a[s][SRC_TABT] = tabort_p;
      evt_a[s][SRC_EXT]  = ext_irq;
    end

    xirq_side #(.DW(DW), .HAS_POL(s == 1)) u_side (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_a[s]),
      .addr       (addr_a[s]),
      .wdata      (wdata_a[s]),
      .rdata      (rdata_a[s]),
      .evt_in     (evt_a[s]),
      .mb_rx_data (tx_data_a[OTHER]),
      .mb_tx_we   (tx_we_a[s]),
      .mb_tx_data (tx_data_a[s]),
      .mb_rx_we   (tx_we_a[OTHER]),
      .irq_o      (irq_a[s]),
      .stat_o     (stat_a[s]),
      .mask_o     (mask_a[s]),
      .pol_o      (pol_a[s])
    );
  end

  assign h_rdata     = rdata_a[0];
  assign l_rdata     = rdata_a[1];
  assign host_irq    = irq_a[0];
  assign loc_irq_pin = irq_a[1];

  assign host_stat = stat_a[0];
  assign loc_stat  = stat_a[1];
  assign host_mask = mask_a[0];
  assign loc_mask  = mask_a[1];
  assign loc_pol   = pol_a[1];
endmodule

// File: rtl/xirq_hub_chk.sv
module xirq_hub_chk #(
  parameter int NSRC = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            dma_done_p,
  input logic            q_nempty,
  input logic            h_wr_en,
  input logic [1:0]      h_addr,
  input logic            h_clr0,
  input logic            host_irq,
  input logic            loc_irq_pin,
  input logic [NSRC-1:0] host_stat,
  input logic [NSRC-1:0] loc_stat,
  input logic [NSRC-1:0] host_mask,
  input logic [NSRC-1:0] loc_mask,
  input logic            loc_pol
);
  // R2
  dma_sets_both_chk: assert property (@(posedge clk) disable iff (rst)
    dma_done_p |=> (host_stat[0] && loc_stat[0]));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (host_stat[0] && !(h_wr_en && h_addr == 2'd0 && h_clr0)) |=> host_stat[0]);

  // R4
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_done_p && h_wr_en && h_addr == 2'd0 && h_clr0) |=> host_stat[0]);

  // R5
  level_high_chk: assert property (@(posedge clk) disable iff (rst)
    q_nempty |=> (host_stat[2] && loc_stat[2]));

  // R5
  level_low_chk: assert property (@(posedge clk) disable iff (rst)
    !q_nempty |=> (!host_stat[2] && !loc_stat[2]));

  // R6
  cross_mbox_chk: assert property (@(posedge clk) disable iff (rst)
    (h_wr_en && h_addr == 2'd2) |=> loc_stat[1]);

  // R8
  host_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(host_stat & host_mask)) |=> !host_irq);

  // R9
  loc_idle_low_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|(loc_stat & loc_mask)) && !loc_pol) |=> loc_irq_pin);
endmodule

bind xirq_hub xirq_hub_chk #(.NSRC(xirq_pkg::NSRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dma_done_p  (dma_done_p),
  .q_nempty    (q_nempty),
  .h_wr_en     (h_wr_en),
  .h_addr      (h_addr),
  .h_clr0      (h_wdata[0]),
  .host_irq    (host_irq),
  .loc_irq_pin (loc_irq_pin),
  .host_stat   (host_stat),
  .loc_stat    (loc_stat),
  .host_mask   (host_mask),
  .loc_mask    (loc_mask),
  .loc_pol     (loc_pol)
);

// File: tb/test_xirq_hub.sv
module test_xirq_hub;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_done_p = 0, q_ovf_p = 0, mabort_p = 0, tabort_p = 0;
  logic q_nempty = 0, ext_irq = 0;
  logic h_wr_en = 0, l_wr_en = 0;
  logic [1:0] h_addr = 0, l_addr = 0;
  logic [DW-1:0] h_wdata = 0, l_wdata = 0;
  logic [DW-1:0] h_rdata, l_rdata;
  logic host_irq, loc_irq_pin;

  always #4 clk = ~clk;

  xirq_hub #(.DW(DW)) i_xirq_hub (
    .clk(clk), .rst(rst),
    .dma_done_p(dma_done_p), .q_ovf_p(q_ovf_p), .mabort_p(mabort_p), .tabort_p(tabort_p),
    .q_nempty(q_nempty), .ext_irq(ext_irq),
    .h_wr_en(h_wr_en), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq(host_irq),
    .l_wr_en(l_wr_en), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .loc_irq_pin(loc_irq_pin)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [6:0]    m_stat [2];
  logic [6:0]    m_mask [2];
  logic [DW-1:0] m_mbox [2];
  logic          m_pol;
  logic [DW-1:0] e_hrd, e_lrd;
  logic          e_hirq, e_lpin;
  bit            m_valid = 0;

  function automatic logic [DW-1:0] m_read(int s, logic [1:0] a);
    case (a)
      2'd0: return {25'd0, m_stat[s]};
      2'd1: return {25'd0, m_mask[s]};
      2'd2: return m_mbox[s];
      default: return (s == 1) ? {31'd0, m_pol} : '0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [6:0]    nstat [2];
    logic          wr [2];
    logic [1:0]    ad [2];
    logic [DW-1:0] wd [2];
    bit            any_l;
    m_valid = 1;
    if (rst) begin
      for (int s = 0; s < 2; s++) begin
        m_stat[s] = '0; m_mask[s] = '0; m_mbox[s] = '0;
      end
      m_pol = 0; e_hrd = '0; e_lrd = '0; e_hirq = 0; e_lpin = 1;
    end else begin
      e_hrd  = m_read(0, h_addr);
      e_lrd  = m_read(1, l_addr);
      e_hirq = |(m_stat[0] & m_mask[0]);
      any_l  = |(m_stat[1] & m_mask[1]);
      e_lpin = m_pol ? any_l : !any_l;
      wr[0] = h_wr_en; ad[0] = h_addr; wd[0] = h_wdata;
      wr[1] = l_wr_en; ad[1] = l_addr; wd[1] = l_wdata;
      for (int s = 0; s < 2; s++) begin
        nstat[s] = m_stat[s];
        if (wr[s] && ad[s] == 2'd0) nstat[s] = nstat[s] & ~(wd[s][6:0] & 7'b0111011);
        if (dma_done_p) nstat[s][0] = 1;
        if (q_ovf_p)    nstat[s][3] = 1;
        if (mabort_p)   nstat[s][4] = 1;
        if (tabort_p)   nstat[s][5] = 1;
        if (wr[1-s] && ad[1-s] == 2'd2) begin
          nstat[s][1] = 1;
          m_mbox[s]   = wd[1-s];
        end
        nstat[s][2] = q_nempty;
        nstat[s][6] = ext_irq;
        if (wr[s] && ad[s] == 2'd1) m_mask[s] = wd[s][6:0];
      end
      if (wr[1] && ad[1] == 2'd3) m_pol = wd[1][0];
      m_stat[0] = nstat[0];
      m_stat[1] = nstat[1];
    end
  end

  task automatic chk(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // R10 R8 R9: every output compared on every cycle
  always @(negedge clk) begin
    if (m_valid) begin
      chk(h_rdata === e_hrd, "h_rdata", h_rdata, e_hrd);
      chk(l_rdata === e_lrd, "l_rdata", l_rdata, e_lrd);
      chk(host_irq === e_hirq, "host_irq", {31'd0, host_irq}, {31'd0, e_hirq});
      chk(loc_irq_pin === e_lpin, "loc_irq_pin", {31'd0, loc_irq_pin}, {31'd0, e_lpin});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); h_wr_en = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr_en = 0;
  endtask

  task automatic lw(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); l_wr_en = 1; l_addr = a; l_wdata = d;
    @(negedge clk); l_wr_en = 0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: dma_done_p = 1;
      1: q_ovf_p    = 1;
      2: mabort_p   = 1;
      default: tabort_p = 1;
    endcase
    @(negedge clk);
    dma_done_p = 0; q_ovf_p = 0; mabort_p = 0; tabort_p = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    for (int a = 0; a < 4; a++) begin
      h_addr = 2'(a); l_addr = 2'(a); idle(2);
    end

    cur_req = "R7";
    hw(2'd1, 32'hFFFF_FF7F);
    lw(2'd1, 32'h0000_0029);
    h_addr = 2'd1; l_addr = 2'd1; idle(2);

    cur_req = "R2";
    h_addr = 2'd0; l_addr = 2'd0;
    for (int k = 0; k < 4; k++) begin
      pulse(k); idle(3);
    end

    cur_req = "R3";
    hw(2'd0, 32'h0000_0018); idle(2);
    lw(2'd0, 32'h0000_007F); idle(2);

    cur_req = "R4";
    @(negedge clk); dma_done_p = 1; h_wr_en = 1; h_addr = 2'd0; h_wdata = 32'h1;
    @(negedge clk); dma_done_p = 0; h_wr_en = 0;
    idle(2);
    hw(2'd0, 32'h7F); idle(2);

    cur_req = "R5";
    q_nempty = 1; idle(3);
    hw(2'd0, 32'h44); idle(2);
    q_nempty = 0; ext_irq = 1; idle(3);
    ext_irq = 0; idle(3);

    cur_req = "R6";
    hw(2'd2, 32'hCAFE_0001);
    l_addr = 2'd2; idle(2);
    lw(2'd2, 32'h1234_5678);
    h_addr = 2'd2; idle(2);
    @(negedge clk); h_wr_en = 1; l_wr_en = 1; h_wdata = 32'hA5A5_0F0F; l_wdata = 32'h5A5A_F0F0;
    @(negedge clk); h_wr_en = 0; l_wr_en = 0;
    idle(2);
    h_addr = 2'd0; l_addr = 2'd0; idle(2);

    cur_req = "R9";
    lw(2'd3, 32'h1); l_addr = 2'd3; idle(3);
    hw(2'd3, 32'hFFFF_FFFF); h_addr = 2'd3; idle(2);
    lw(2'd0, 32'h7F); idle(3);
    lw(2'd3, 32'h0); idle(3);

    cur_req = "R11";
    hw(2'd1, 32'h0); lw(2'd1, 32'h7F);
    pulse(2); idle(3);
    hw(2'd1, 32'h10); idle(3);

    cur_req = "R8";
    hw(2'd0, 32'h7F); idle(3);
    pulse(3); idle(2);
    hw(2'd1, 32'h20); idle(3);

    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      dma_done_p = ($urandom % 8) == 0;
      q_ovf_p    = ($urandom % 10) == 0;
      mabort_p   = ($urandom % 12) == 0;
      tabort_p   = ($urandom % 12) == 0;
      if (($urandom % 16) == 0) q_nempty = ~q_nempty;
      if (($urandom % 20) == 0) ext_irq = ~ext_irq;
      h_wr_en = ($urandom % 4) == 0; h_addr = 2'($urandom); h_wdata = $urandom;
      l_wr_en = ($urandom % 4) == 0; l_addr = 2'($urandom); l_wdata = $urandom;
    end
    @(negedge clk);
    dma_done_p = 0; q_ovf_p = 0; mabort_p = 0; tabort_p = 0; h_wr_en = 0; l_wr_en = 0;
    idle(3);
    summary();
  end
endmodule